// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read-only, direct-mapped cache controller. A small, fully associative victim buffer sits on its refill path. The processor presents line addresses on a valid/ready request port. The controller returns one whole line per request, together with a status flag that says where the line came from.

The buffer holds only lines that were pushed out of the main array. On a main-array miss the controller searches the buffer before it asks the next level.

- On a buffer hit, the buffer line and the line in the indexed main slot change places. No memory traffic occurs.
- On a miss in both places, the controller fetches the line from the next level. The valid line it displaces goes into the buffer. That line takes an invalid buffer entry if one exists; otherwise it takes the least recently used entry.

Back-pressure rules:
- A request transfers on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` stays low from the acceptance of any miss until its response. Only one request is ever in flight.
- Responses are single-cycle pulses on `resp_valid` and cannot be stalled, so the consumer must take them.
- On the memory side, `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready` is seen.
- The memory answers with a one-cycle `mem_resp_valid` pulse that carries the full line.

Top module: `vc_cache_top`

## Requirements
- R1: A request that hits the main array responds on the cycle after acceptance with the stored line and `resp_main_hit`. It issues no memory request and leaves the victim buffer unchanged.
- R2: On a main-array miss whose line address is held in the victim buffer, no memory request is made. The response arrives two cycles after acceptance, with `resp_victim_hit` and the buffered line.
- R3: After a victim hit, the requested line lives in the main array, so a repeat access is a main hit. The line it displaced lives in the buffer, so an access to it is a victim hit.
- R4: On a miss in both places, exactly one memory request is issued, carrying the requested line address. The memory's line is returned with `resp_full_miss` and installed in the main array.
- R5: A refill that displaces a valid main line stores that line, with its full address, in the buffer. A refill into an invalid main slot inserts nothing.
- R6: A new victim takes an invalid buffer entry when one exists, otherwise the least recently used one. The entry written by a swap becomes most recently used.
- R7: Two line addresses that alternate on one main index hit the buffer on every access after the first two misses.
- R8: `req_ready` is low from the acceptance of a miss until the cycle its response is presented.
- R9: Every `resp_valid` pulse carries exactly one of the three status flags.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged.
- R11: After reset, `req_ready` is high and `resp_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor read request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Requested line address (index in the low IDX_W bits) |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_data | output | LINE_W | Returned line |
| resp_main_hit | output | 1 | Response came from the main array |
| resp_victim_hit | output | 1 | Response came from the victim buffer via a swap |
| resp_full_miss | output | 1 | Response came from the next level |
| mem_req_valid | output | 1 | Next-level line request valid |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_addr | output | ADDR_W | Line address requested from the next level |
| mem_resp_valid | input | 1 | Next-level line return pulse |
| mem_resp_data | input | LINE_W | Line returned by the next level |

## Verification
The bench builds the block with a 6-bit line address, four main sets, 16-bit lines and a two-entry victim buffer. With only four sets, a handful of addresses that share an index produce conflict misses, swaps and alternating pairs. With only two buffer entries, the third victim forces a least-recently-used eviction. That makes replacement and most-recently-used promotion visible through whether a later access reports a victim hit or a full miss. The memory model can stall its ready and stretch its latency, which exercises the hold and busy rules.

// File: rtl/vc_pkg.sv
package vc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWAP  = 2'd1,
    ST_MREQ  = 2'd2,
    ST_MWAIT = 2'd3
  } vc_state_e;

endpackage

// File: rtl/vc_main_array.sv
module vc_main_array #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int LINE_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic                    rd_valid,
  output logic [ADDR_W-IDX_W-1:0] rd_tag,
  output logic [LINE_W-1:0]       rd_data,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [ADDR_W-IDX_W-1:0] wr_tag,
  input  logic [LINE_W-1:0]       wr_data
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;

  logic [SETS-1:0]  slot_valid;
  logic [TAG_W-1:0] slot_tag  [SETS];
  logic [LINE_W-1:0] slot_data [SETS];

  assign rd_valid = slot_valid[rd_idx];
  assign rd_tag   = slot_tag[rd_idx];
  assign rd_data  = slot_data[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_valid <= '0;
    end else if (wr_en) begin
      slot_valid[wr_idx] <= 1'b1;
      slot_tag[wr_idx]   <= wr_tag;
      slot_data[wr_idx]  <= wr_data;
    end
  end

  // R4
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> slot_valid[$past(wr_idx)]);

endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int ADDR_W = 12,
  parameter int LINE_W = 32,
  parameter int DEPTH  = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [ADDR_W-1:0]                      lk_addr,
  output logic                                   lk_hit,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] lk_sel,
  output logic [LINE_W-1:0]                      lk_data,
  input  logic                                   sw_en,
  input  logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] sw_sel,
  input  logic [ADDR_W-1:0]                      sw_addr,
  input  logic [LINE_W-1:0]                      sw_data,
  input  logic                                   sw_keep,
  input  logic                                   ins_en,
  input  logic [ADDR_W-1:0]                      ins_addr,
  input  logic [LINE_W-1:0]                      ins_data
);
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  e_valid;
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [LINE_W-1:0] e_data [DEPTH];
  logic [SEL_W-1:0]  e_age  [DEPTH];   // 0 = most recently used
  logic [DEPTH-1:0]  hit_vec;

  logic             free_found;
  logic [SEL_W-1:0] ins_slot;
  logic             upd_en;
  logic [SEL_W-1:0] upd_sel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = e_valid[g] && (e_addr[g] == lk_addr);
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i] && !lk_hit) begin
        lk_hit = 1'b1;
        lk_sel = SEL_W'(i);
      end
    end
  end
  assign lk_data = e_data[lk_sel];

  always_comb begin
    free_found = 1'b0;
    ins_slot   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!e_valid[i] && !free_found) begin
        free_found = 1'b1;
        ins_slot   = SEL_W'(i);
      end
    end
    if (!free_found) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (e_age[i] == SEL_W'(DEPTH - 1)) ins_slot = SEL_W'(i);
      end
    end
  end

  assign upd_en  = sw_en || ins_en;
  assign upd_sel = sw_en ? sw_sel : ins_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_valid <= '0;
      for (int i = 0; i < DEPTH; i++) e_age[i] <= SEL_W'(i);
    end else if (upd_en) begin
      e_addr[upd_sel]  <= sw_en ? sw_addr : ins_addr;
      e_data[upd_sel]  <= sw_en ? sw_data : ins_data;
      e_valid[upd_sel] <= sw_en ? sw_keep : 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if (SEL_W'(i) == upd_sel)            e_age[i] <= '0;
        else if (e_age[i] < e_age[upd_sel])  e_age[i] <= e_age[i] + 1'b1;
      end
    end
  end

  // R5
  no_duplicate_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R6
  single_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_en, ins_en}));

  // R6
  written_is_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (e_age[$past(upd_sel)] == '0));

endmodule

// File: rtl/vc_cache_top.sv
module vc_cache_top #(
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 4,
  parameter int LINE_W   = 32,
  parameter int VB_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic [LINE_W-1:0] resp_data,
  output logic              resp_main_hit,
  output logic              resp_victim_hit,
  output logic              resp_full_miss,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [LINE_W-1:0] mem_resp_data
);
  import vc_pkg::*;

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SEL_W = (VB_DEPTH > 1) ? $clog2(VB_DEPTH) : 1;

  vc_state_e         state;
  logic [ADDR_W-1:0] s_addr;
  logic [ADDR_W-1:0] look_addr;
  logic [IDX_W-1:0]  look_idx;

  logic              m_valid;
  logic [TAG_W-1:0]  m_tag;
  logic [LINE_W-1:0] m_data;
  logic              main_hit;
  logic              m_wr_en;
  logic [LINE_W-1:0] m_wr_data;

  logic              vb_hit;
  logic [SEL_W-1:0]  vb_sel;
  logic [LINE_W-1:0] vb_data;
  logic              vb_swap;
  logic              vb_ins;

  logic              accept;
  logic              fill_now;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign look_addr = (state == ST_IDLE) ? req_addr : s_addr;
  assign look_idx  = look_addr[IDX_W-1:0];
  assign main_hit  = m_valid && (m_tag == look_addr[ADDR_W-1:IDX_W]);
  assign fill_now  = (state == ST_MWAIT) && mem_resp_valid;

  assign m_wr_en   = (state == ST_SWAP) || fill_now;
  assign m_wr_data = (state == ST_SWAP) ? vb_data : mem_resp_data;
  assign vb_swap   = (state == ST_SWAP);
  assign vb_ins    = fill_now && m_valid;

  assign mem_req_valid = (state == ST_MREQ);
  assign mem_req_addr  = s_addr;

  vc_main_array #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LINE_W(LINE_W)
  ) u_main (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (look_idx),
    .rd_valid(m_valid),
    .rd_tag  (m_tag),
    .rd_data (m_data),
    .wr_en   (m_wr_en),
    .wr_idx  (s_addr[IDX_W-1:0]),
    .wr_tag  (s_addr[ADDR_W-1:IDX_W]),
    .wr_data (m_wr_data)
  );

  vc_victim_buf #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .DEPTH(VB_DEPTH)
  ) u_vbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_addr (look_addr),
    .lk_hit  (vb_hit),
    .lk_sel  (vb_sel),
    .lk_data (vb_data),
    .sw_en   (vb_swap),
    .sw_sel  (vb_sel),
    .sw_addr ({m_tag, look_idx}),
    .sw_data (m_data),
    .sw_keep (m_valid),
    .ins_en  (vb_ins),
    .ins_addr({m_tag, look_idx}),
    .ins_data(m_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= ST_IDLE;
      s_addr          <= '0;
      resp_valid      <= 1'b0;
      resp_data       <= '0;
      resp_main_hit   <= 1'b0;
      resp_victim_hit <= 1'b0;
      resp_full_miss  <= 1'b0;
    end else begin
      resp_valid      <= 1'b0;
      resp_main_hit   <= 1'b0;
      resp_victim_hit <= 1'b0;
      resp_full_miss  <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          s_addr <= req_addr;
          if (main_hit) begin
            resp_valid    <= 1'b1;
            resp_main_hit <= 1'b1;
            resp_data     <= m_data;
          end else if (vb_hit) begin
            state <= ST_SWAP;
          end else begin
            state <= ST_MREQ;
          end
        end
        ST_SWAP: begin
          resp_valid      <= 1'b1;
          resp_victim_hit <= 1'b1;
          resp_data       <= vb_data;
          state           <= ST_IDLE;
        end
        ST_MREQ: if (mem_req_ready) state <= ST_MWAIT;
        ST_MWAIT: if (mem_resp_valid) begin
          resp_valid     <= 1'b1;
          resp_full_miss <= 1'b1;
          resp_data      <= mem_resp_data;
          state          <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  one_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $onehot({resp_main_hit, resp_victim_hit, resp_full_miss}));

  // R10
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R8
  busy_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !main_hit) |=> !req_ready);

  // R2
  swap_needs_vb_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SWAP) |-> (vb_hit && !mem_req_valid));

endmodule

// File: tb/vc_cache_top_tb.sv
module vc_cache_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 6;
  localparam int IW  = 2;
  localparam int LW  = 16;
  localparam int VBD = 2;
  localparam int NS  = 1 << IW;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic resp_valid, resp_main_hit, resp_victim_hit, resp_full_miss;
  logic [LW-1:0] resp_data;
  logic mem_req_valid, mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic mem_resp_valid;
  logic [LW-1:0] mem_resp_data;

  int checks = 0;
  int errors = 0;
  int mem_reqs = 0;
  int hold_err = 0;
  int mem_stall = 0;
  int mem_lat = 1;
  logic [AW-1:0] last_mem_addr;

  // reference state: main slots and buffer ordered from most recent
  bit            mdl_mv [NS];
  logic [AW-1:0] mdl_ma [NS];
  logic [AW-1:0] mdl_vb [VBD];
  int            mdl_vn;

  always #(CLK_PERIOD/2) clk = ~clk;

  vc_cache_top #(.ADDR_W(AW), .IDX_W(IW), .LINE_W(LW), .VB_DEPTH(VBD)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_main_hit(resp_main_hit), .resp_victim_hit(resp_victim_hit),
    .resp_full_miss(resp_full_miss),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
  );

  function automatic logic [LW-1:0] line_of(logic [AW-1:0] a);
    return {a[3:0], ~a, a};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // next-level memory model
  initial begin
    mem_req_ready  = 1'b0;
    mem_resp_valid = 1'b0;
    mem_resp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [AW-1:0] a0;
        a0 = mem_req_addr;
        for (int k = 0; k < mem_stall; k++) begin
          @(negedge clk);
          if (!mem_req_valid || mem_req_addr != a0) hold_err++;
        end
        mem_req_ready = 1'b1;
        last_mem_addr = mem_req_addr;
        mem_reqs++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int k = 0; k < mem_lat; k++) @(negedge clk);
        mem_resp_valid = 1'b1;
        mem_resp_data  = line_of(last_mem_addr);
        @(negedge clk);
        mem_resp_valid = 1'b0;
      end
    end
  end

  task automatic model_access(input logic [AW-1:0] a, output int kind);
    int i;
    int p;
    logic [AW-1:0] disp;
    i = int'(a[IW-1:0]);
    p = -1;
    if (mdl_mv[i] && mdl_ma[i] == a) begin
      kind = 1;
      return;
    end
    for (int k = 0; k < mdl_vn; k++) if (mdl_vb[k] == a) p = k;
    if (p >= 0) begin
      kind = 2;
      disp = mdl_ma[i];
      for (int k = p; k > 0; k--) mdl_vb[k] = mdl_vb[k-1];
      mdl_vb[0] = disp;
      mdl_ma[i] = a;
    end else begin
      kind = 3;
      if (mdl_mv[i]) begin
        for (int k = VBD - 1; k > 0; k--) mdl_vb[k] = mdl_vb[k-1];
        mdl_vb[0] = mdl_ma[i];
        if (mdl_vn < VBD) mdl_vn++;
      end
      mdl_ma[i] = a;
      mdl_mv[i] = 1'b1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    mem_stall = 0;
    mem_lat = 1;
    for (int k = 0; k < NS; k++) mdl_mv[k] = 1'b0;
    mdl_vn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one read; returns observed kind (1 main, 2 victim, 3 miss, 0 none)
  task automatic do_read(input logic [AW-1:0] a, output int got);
    int exp_kind;
    int lat;
    int m0;
    bit busy_bad;
    string rq;
    model_access(a, exp_kind);
    rq = (exp_kind == 1) ? "R1" : (exp_kind == 2) ? "R2" : "R4";
    while (!req_ready) @(negedge clk);
    m0 = mem_reqs;
    req_valid = 1'b1;
    req_addr = a;
    @(posedge clk);
    lat = 0;
    busy_bad = 1'b0;
    got = 0;
    while (lat < 500) begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
      if (resp_valid) break;
      if (req_ready) busy_bad = 1'b1;
    end
    if (resp_valid) got = resp_main_hit ? 1 : resp_victim_hit ? 2 : resp_full_miss ? 3 : 0;
    check(resp_valid, rq, "response seen", int'(resp_valid), 1);
    check(resp_data == line_of(a), rq, "line data", int'(resp_data), int'(line_of(a)));
    check(got == exp_kind, rq, "status kind", got, exp_kind);
    // R9
    check($countones({resp_main_hit, resp_victim_hit, resp_full_miss}) == 1, "R9",
          "status flags", int'({resp_main_hit, resp_victim_hit, resp_full_miss}), 1);
    if (exp_kind == 1) check(lat == 1, "R1", "latency", lat, 1);
    if (exp_kind == 2) check(lat == 2, "R2", "latency", lat, 2);
    if (exp_kind == 3) begin
      check(mem_reqs - m0 == 1, "R4", "memory requests", mem_reqs - m0, 1);
      check(last_mem_addr == a, "R4", "memory address", int'(last_mem_addr), int'(a));
    end else begin
      check(mem_reqs == m0, rq, "no memory request", mem_reqs - m0, 0);
    end
    if (exp_kind != 1) check(!busy_bad, "R8", "req_ready low while busy", int'(busy_bad), 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    // R11
    check(req_ready == 1'b1, "R11", "req_ready after reset", int'(req_ready), 1);
    check(resp_valid == 1'b0, "R11", "resp_valid after reset", int'(resp_valid), 0);
    check(mem_req_valid == 1'b0, "R11", "mem_req_valid after reset", int'(mem_req_valid), 0);
  endtask

  task automatic t_cold_and_hit();
    int g;
    do_reset();
    do_read(6'h01, g);
    check(g == 3, "R4", "cold access is full miss", g, 3);
    do_read(6'h01, g);
    check(g == 1, "R1", "repeat access is main hit", g, 1);
    do_read(6'h21, g);
    check(g == 3, "R4", "conflicting line is full miss", g, 3);
  endtask

  task automatic t_invalid_slot();
    int g;
    do_reset();
    do_read(6'h00, g);
    do_read(6'h04, g);
    do_read(6'h01, g);
    do_read(6'h02, g);
    do_read(6'h03, g);
    // R5: cold fills into empty slots must not have pushed 0x00 out of the buffer
    do_read(6'h00, g);
    check(g == 2, "R5", "evicted line kept across cold fills", g, 2);
    do_read(6'h04, g);
    check(g == 2, "R5", "swapped-out line held with full address", g, 2);
  endtask

  task automatic t_swap();
    int g;
    do_reset();
    do_read(6'h10, g);
    do_read(6'h14, g);
    do_read(6'h10, g);
    check(g == 2, "R2", "displaced line found in buffer", g, 2);
    do_read(6'h10, g);
    check(g == 1, "R3", "swapped-in line now in main", g, 1);
    do_read(6'h14, g);
    check(g == 2, "R3", "swapped-out line now in buffer", g, 2);
  endtask

  task automatic t_pingpong();
    int g;
    int bad = 0;
    do_reset();
    do_read(6'h03, g);
    do_read(6'h07, g);
    for (int k = 0; k < 8; k++) begin
      do_read((k % 2 == 0) ? 6'h03 : 6'h07, g);
      if (g != 2) bad++;
    end
    // R7
    check(bad == 0, "R7", "alternating pair non-victim-hits", bad, 0);
  endtask

  task automatic t_lru();
    int g;
    do_reset();
    do_read(6'h02, g);
    do_read(6'h06, g);
    do_read(6'h0A, g);
    do_read(6'h0E, g);
    do_read(6'h02, g);
    check(g == 3, "R6", "oldest victim was replaced", g, 3);
    do_read(6'h0A, g);
    check(g == 2, "R6", "newer victim retained", g, 2);
    do_read(6'h06, g);
    check(g == 3, "R6", "line evicted earlier misses", g, 3);
    do_read(6'h02, g);
    check(g == 2, "R6", "swap-written entry promoted to most recent", g, 2);
    do_read(6'h0E, g);
    check(g == 3, "R6", "least recent entry replaced", g, 3);
  endtask

  task automatic t_backpressure();
    int g;
    do_reset();
    mem_stall = 3;
    mem_lat = 4;
    hold_err = 0;
    do_read(6'h30, g);
    do_read(6'h34, g);
    do_read(6'h30, g);
    check(g == 2, "R8", "victim hit after stalled refills", g, 2);
    // R10
    check(hold_err == 0, "R10", "request held while stalled", hold_err, 0);
    mem_stall = 0;
    mem_lat = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_cold_and_hit();
    t_invalid_slot();
    t_swap();
    t_pingpong();
    t_lru();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule